// File: doc/BRIEF.md
# Card Data FIFO Packing Engine

This block sits between a host-facing word FIFO and a byte-wide memory-card data port. The FIFO holds 32-bit words. The card side moves one byte at a time. A transfer starts with a one-cycle `start` pulse, which loads a 16-bit byte length and picks the direction.

In the card-to-host direction, the block gathers incoming card bytes into words in little-endian order and pushes each word into the FIFO. The host drains the FIFO through its pop port. In the host-to-card direction, the host fills the FIFO through its push port. The block then pops words and sends their bytes to the card, lowest byte first.

A byte counter tracks how much of the transfer remains. When it reaches zero, two end flags are set. The engine drops back to idle once the counter is zero and the FIFO is empty. FIFO level flags are reported only for the active direction and are all low when the block is idle.

Top module: `card_fifo_packer`

## Requirements
- R1: The FIFO holds 16 words of 32 bits, first in first out. A push while it holds 16 words is dropped. A pop while it is empty has no effect, and `host_rdata` reads zero whenever the FIFO is empty.
- R2: A `start` pulse does four things: it loads `len` into `bytes_left`, raises `busy`, clears both end flags and latches `dir` (1 = card to host, 0 = host to card).
- R3: In the card-to-host direction, a card byte is accepted only when all of these hold: `card_data_rdy` is high, `bytes_left` is nonzero and the FIFO is not full. At most one byte is accepted per cycle, and each accepted byte lowers `bytes_left` by one.
- R4: Card bytes are packed little-endian: the first byte of each group of four lands in bits 7:0, the fourth in bits 31:24.
- R5: When the transfer ends partway through a word, that word is still pushed, with its unfilled upper bytes zero.
- R6: In the host-to-card direction, a byte is offered while `bytes_left` is nonzero and either the FIFO holds a word or bytes of an already popped word remain. Bytes go out from bits 7:0 upward, one per cycle at most, and each lowers `bytes_left` by one.
- R7: Once the engine is busy with `bytes_left` at zero, `data_end` and `block_end` are set on the next cycle. They stay set until the next `start`.
- R8: `busy` clears one cycle after `bytes_left` is zero and the FIFO is empty.
- R9: While busy, the flags track FIFO occupancy as follows:
  - half-empty is high for occupancy 8 or less;
  - half-full is high for occupancy 8 or more;
  - full is high at 16;
  - empty is high at 0;
  - available is high for any nonzero occupancy.
- R10: The `rx_*` flags are driven only in the card-to-host direction and the `tx_*` flags only in the other direction. All FIFO flags are low while idle.
- R11: A host pop in the same cycle as an engine push, or a host push in the same cycle as an engine pop, both take effect. If the engine and the host push in the same cycle, the engine's word wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer |
| dir | input | 1 | Direction, sampled at start (1 = card to host) |
| len | input | 16 | Transfer length in bytes, sampled at start |
| host_push | input | 1 | Write `host_wdata` into the FIFO |
| host_wdata | input | 32 | Word to write |
| host_pop | input | 1 | Remove the head word |
| host_rdata | output | 32 | Head word, zero when empty |
| card_data_rdy | input | 1 | Card has read data ready |
| card_rx_valid | input | 1 | Card byte valid |
| card_rx_data | input | 8 | Card byte |
| card_rx_ready | output | 1 | Engine takes the card byte this cycle |
| card_tx_valid | output | 1 | Byte offered to the card |
| card_tx_data | output | 8 | Byte to the card |
| card_tx_ready | input | 1 | Card takes the byte this cycle |
| busy | output | 1 | Transfer in progress |
| bytes_left | output | 16 | Remaining byte count |
| data_end | output | 1 | Counter reached zero |
| block_end | output | 1 | Counter reached zero (block flag) |
| tx_active | output | 1 | Busy, host to card |
| tx_half_empty | output | 1 | Host-to-card occupancy at most 8 |
| tx_full | output | 1 | Host-to-card occupancy 16 |
| tx_empty | output | 1 | Host-to-card occupancy 0 |
| tx_avail | output | 1 | Host-to-card occupancy nonzero |
| rx_active | output | 1 | Busy, card to host |
| rx_half_full | output | 1 | Card-to-host occupancy at least 8 |
| rx_full | output | 1 | Card-to-host occupancy 16 |
| rx_empty | output | 1 | Card-to-host occupancy 0 |
| rx_avail | output | 1 | Card-to-host occupancy nonzero |

## Verification
The FIFO can be pushed and popped in the same cycle by different parties, and that is the case the bench aims at.

- In the card-to-host direction, the bench first lets the FIFO fill to 16 words with the card still streaming. It then pops one word every cycle, so some host pops fall on the same edges as engine pushes.
- In the host-to-card direction, it pushes a new word on the edge where the engine pops the first word, then stalls the card's ready to stretch the overlap.

A word scoreboard and a byte scoreboard judge both cases. Every expected item must arrive exactly once and in order, and the engine must finish idle with its end flags set.

// File: rtl/card_fifo_packer.sv
module card_fifo_packer #(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              dir,
  input  logic [LEN_W-1:0]  len,
  input  logic              host_push,
  input  logic [WORD_W-1:0] host_wdata,
  input  logic              host_pop,
  output logic [WORD_W-1:0] host_rdata,
  input  logic              card_data_rdy,
  input  logic              card_rx_valid,
  input  logic [7:0]        card_rx_data,
  output logic              card_rx_ready,
  output logic              card_tx_valid,
  output logic [7:0]        card_tx_data,
  input  logic              card_tx_ready,
  output logic              busy,
  output logic [LEN_W-1:0]  bytes_left,
  output logic              data_end,
  output logic              block_end,
  output logic              tx_active,
  output logic              tx_half_empty,
  output logic              tx_full,
  output logic              tx_empty,
  output logic              tx_avail,
  output logic              rx_active,
  output logic              rx_half_full,
  output logic              rx_full,
  output logic              rx_empty,
  output logic              rx_avail
);
  localparam int AW  = $clog2(DEPTH);
  localparam int CW  = AW + 1;
  localparam int NB  = WORD_W / 8;
  localparam int NBW = $clog2(NB) + 1;
  localparam logic [CW-1:0]  FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0]  HALF_CNT = CW'(DEPTH / 2);
  localparam logic [NBW-1:0] LAST_B   = NBW'(NB - 1);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     rd_ptr;
  logic [CW-1:0]     count;
  logic              en_q, dir_q, end_q;
  logic [LEN_W-1:0]  cnt_q;
  logic [WORD_W-1:0] acc_q, txw_q;
  logic [NBW-1:0]    acc_n, txn_q;

  logic              full, empty, rx_take, tx_take, eng_push, eng_pop, do_push, do_pop;
  logic [WORD_W-1:0] head, acc_next, push_word;
  logic [AW-1:0]     wr_ptr;

  assign full     = (count == FULL_CNT);
  assign empty    = (count == '0);
  assign head     = mem[rd_ptr];
  assign wr_ptr   = rd_ptr + count[AW-1:0];
  assign host_rdata = empty ? '0 : head;

  assign card_rx_ready = en_q & dir_q & (cnt_q != '0) & card_data_rdy & ~full;
  assign rx_take  = card_rx_valid & card_rx_ready;
  assign acc_next = acc_q | ({{(WORD_W-8){1'b0}}, card_rx_data} << (8 * acc_n));
  assign eng_push = rx_take & ((acc_n == LAST_B) | (cnt_q == LEN_W'(1)));

  assign card_tx_valid = en_q & ~dir_q & (cnt_q != '0) & (~empty | (txn_q != '0));
  assign card_tx_data  = (txn_q == '0) ? head[7:0] : txw_q[7:0];
  assign tx_take  = card_tx_valid & card_tx_ready;
  assign eng_pop  = tx_take & (txn_q == '0);

  assign do_push   = (eng_push | host_push) & ~full;
  assign push_word = eng_push ? acc_next : host_wdata;
  assign do_pop    = (eng_pop | host_pop) & ~empty;

  always_ff @(posedge clk)
    if (do_push) mem[wr_ptr] <= push_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_pop) rd_ptr <= rd_ptr + AW'(1);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      dir_q <= 1'b0;
      end_q <= 1'b0;
      cnt_q <= '0;
      acc_q <= '0;
      acc_n <= '0;
      txw_q <= '0;
      txn_q <= '0;
    end else if (start) begin
      en_q  <= 1'b1;
      dir_q <= dir;
      end_q <= 1'b0;
      cnt_q <= len;
      acc_q <= '0;
      acc_n <= '0;
      txw_q <= '0;
      txn_q <= '0;
    end else begin
      if (rx_take | tx_take) cnt_q <= cnt_q - LEN_W'(1);
      if (en_q && cnt_q == '0) end_q <= 1'b1;
      if (en_q && cnt_q == '0 && empty) en_q <= 1'b0;
      if (rx_take) begin
        acc_q <= eng_push ? '0 : acc_next;
        acc_n <= eng_push ? '0 : acc_n + NBW'(1);
      end
      if (tx_take) begin
        txw_q <= ((txn_q == '0) ? head : txw_q) >> 8;
        txn_q <= (txn_q == '0) ? LAST_B : txn_q - NBW'(1);
      end
    end
  end

  assign busy       = en_q;
  assign bytes_left = cnt_q;
  assign data_end   = end_q;
  assign block_end  = end_q;

  assign rx_active     = en_q & dir_q;
  assign rx_half_full  = rx_active & (count >= HALF_CNT);
  assign rx_full       = rx_active & full;
  assign rx_empty      = rx_active & empty;
  assign rx_avail      = rx_active & ~empty;
  assign tx_active     = en_q & ~dir_q;
  assign tx_half_empty = tx_active & (count <= HALF_CNT);
  assign tx_full       = tx_active & full;
  assign tx_empty      = tx_active & empty;
  assign tx_avail      = tx_active & ~empty;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT); // R1
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !do_pop) |=> (count == FULL_CNT)); // R1
  AST_RX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_take && !start) |=> (bytes_left == $past(bytes_left) - LEN_W'(1))); // R3
  AST_TX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_take && !start) |=> (bytes_left == $past(bytes_left) - LEN_W'(1))); // R6
  AST_END_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bytes_left == '0 && !start) |=> (data_end && block_end)); // R7
  AST_AUTO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bytes_left == '0 && count == '0 && !start) |=> !busy); // R8
  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && !data_end && bytes_left == $past(len))); // R2
endmodule

// File: tb/card_fifo_packer_tb.sv
module card_fifo_packer_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, dir = 1'b0;
  logic [15:0] len = '0;
  logic        host_push = 1'b0, host_pop = 1'b0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic        card_data_rdy = 1'b0, card_rx_valid = 1'b0, card_rx_ready;
  logic [7:0]  card_rx_data = '0, card_tx_data;
  logic        card_tx_valid, card_tx_ready = 1'b0;
  logic        busy, data_end, block_end;
  logic [15:0] bytes_left;
  logic        tx_active, tx_half_empty, tx_full, tx_empty, tx_avail;
  logic        rx_active, rx_half_full, rx_full, rx_empty, rx_avail;

  card_fifo_packer u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dir(dir), .len(len),
    .host_push(host_push), .host_wdata(host_wdata), .host_pop(host_pop), .host_rdata(host_rdata),
    .card_data_rdy(card_data_rdy), .card_rx_valid(card_rx_valid), .card_rx_data(card_rx_data),
    .card_rx_ready(card_rx_ready), .card_tx_valid(card_tx_valid), .card_tx_data(card_tx_data),
    .card_tx_ready(card_tx_ready), .busy(busy), .bytes_left(bytes_left),
    .data_end(data_end), .block_end(block_end),
    .tx_active(tx_active), .tx_half_empty(tx_half_empty), .tx_full(tx_full),
    .tx_empty(tx_empty), .tx_avail(tx_avail),
    .rx_active(rx_active), .rx_half_full(rx_half_full), .rx_full(rx_full),
    .rx_empty(rx_empty), .rx_avail(rx_avail));

  always #(CLK_P/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  int cyc = 0;
  int tx_mode = 0;
  logic [7:0]  rx_src [$];
  logic [7:0]  exp_tx [$];
  logic [31:0] exp_rx [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // card model, host-to-card side: byte scoreboard monitor
  always begin
    @(negedge clk);
    card_tx_ready = (tx_mode == 0) ? 1'b1 : (tx_mode == 1) ? (cyc % 3 != 0) : 1'b0;
    #1;
    if (rst_n && card_tx_valid && card_tx_ready) begin
      if (exp_tx.size() == 0) chk("R6 unexpected byte", {24'h0, card_tx_data}, 32'hxxxx_xxxx);
      else chk("R6 byte", {24'h0, card_tx_data}, {24'h0, exp_tx.pop_front()});
    end
  end

  // card model, card-to-host side: byte source
  always begin
    @(negedge clk);
    card_rx_valid = (rx_src.size() > 0);
    card_rx_data  = card_rx_valid ? rx_src[0] : 8'h00;
    #1;
    if (rst_n && card_rx_valid && card_rx_ready) void'(rx_src.pop_front());
  end

  task automatic step(); @(negedge clk); endtask

  task automatic push_w(logic [31:0] w);
    host_push = 1'b1; host_wdata = w; step(); host_push = 1'b0;
  endtask

  task automatic pop_chk(string req);
    logic [31:0] e;
    e = (exp_rx.size() > 0) ? exp_rx.pop_front() : 32'h0;
    chk(req, host_rdata, e);
    host_pop = 1'b1; step(); host_pop = 1'b0;
  endtask

  task automatic go(logic d, logic [15:0] l);
    dir = d; len = l; start = 1'b1; step(); start = 1'b0;
  endtask

  task automatic wait_left0();
    for (int i = 0; i < 3000 && bytes_left != 0; i++) step();
  endtask

  task automatic exp_bytes(logic [31:0] w);
    for (int j = 0; j < 4; j++) exp_tx.push_back(w[8*j +: 8]);
  endtask

  task automatic drain(string req);
    for (int i = 0; i < 3000 && exp_rx.size() > 0; i++) begin
      if (rx_avail) pop_chk(req); else step();
    end
  endtask

  task automatic rx_load(int n, int seed);
    logic [31:0] w;
    w = '0;
    for (int i = 0; i < n; i++) begin
      rx_src.push_back(8'(i * 7 + seed));
      w[8*(i%4) +: 8] = 8'(i * 7 + seed);
      if (i % 4 == 3 || i == n - 1) begin exp_rx.push_back(w); w = '0; end
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    repeat (3) step();
    // reset state
    chk("R10 reset busy", {31'h0, busy}, 0);
    chk("R10 reset flags", {22'h0, tx_active, tx_half_empty, tx_full, tx_empty, tx_avail,
        rx_active, rx_half_full, rx_full, rx_empty, rx_avail}, 0);
    chk("R1 reset rdata", host_rdata, 0);
    chk("R2 reset count", {16'h0, bytes_left}, 0);
    chk("R7 reset end", {30'h0, data_end, block_end}, 0);
    rst_n = 1'b1;
    step();

    // R1: pop on empty ignored
    host_pop = 1'b1; step(); host_pop = 1'b0;
    chk("R1 empty rdata", host_rdata, 0);
    push_w(32'hCAFE0001);
    chk("R1 head after empty pop", host_rdata, 32'hCAFE0001);
    host_pop = 1'b1; step(); host_pop = 1'b0;
    chk("R1 empty again", host_rdata, 0);

    // R1/R9: 17 pushes, last dropped; drained to card
    tx_mode = 2;
    for (int k = 0; k < 17; k++) begin
      push_w(32'h1000_0000 + k);
      if (k < 16) exp_bytes(32'h1000_0000 + k);
    end
    go(1'b0, 16'd64);
    chk("R9 tx_full at 16", {31'h0, tx_full}, 1);
    chk("R9 tx half_empty at 16", {31'h0, tx_half_empty}, 0);
    chk("R10 rx flags off in tx", {27'h0, rx_active, rx_half_full, rx_full, rx_empty, rx_avail}, 0);
    tx_mode = 0;
    wait_left0(); step();
    chk("R1 17th word dropped", {31'h0, busy}, 0);
    chk("R6 all bytes sent", exp_tx.size(), 0);
    chk("R7 end flags", {30'h0, data_end, block_end}, 2'b11);

    // R3/R4/R5: 10-byte read
    card_data_rdy = 1'b1;
    rx_load(10, 8'h10);
    go(1'b1, 16'd10);
    wait_left0(); step();
    chk("R7 read end", {30'h0, data_end, block_end}, 2'b11);
    chk("R8 busy while fifo holds", {31'h0, busy}, 1);
    chk("R9 rx flags at 3", {27'h0, rx_active, rx_half_full, rx_full, rx_empty, rx_avail}, 5'b10001);
    chk("R10 tx flags off in rx", {27'h0, tx_active, tx_half_empty, tx_full, tx_empty, tx_avail}, 0);
    pop_chk("R4 word0"); pop_chk("R4 word1"); pop_chk("R5 partial word");
    step();
    chk("R8 idle after drain", {31'h0, busy}, 0);
    chk("R10 idle flags", {22'h0, tx_active, tx_half_empty, tx_full, tx_empty, tx_avail,
        rx_active, rx_half_full, rx_full, rx_empty, rx_avail}, 0);

    // R3: data_rdy gating
    card_data_rdy = 1'b0;
    rx_load(4, 8'h01);
    go(1'b1, 16'd4);
    repeat (5) step();
    chk("R3 held without data_rdy", {16'h0, bytes_left}, 4);
    chk("R9 rx_empty at 0", {31'h0, rx_empty}, 1);
    card_data_rdy = 1'b1;
    wait_left0(); step();
    drain("R4 gated word");
    step();
    chk("R8 idle after gated read", {31'h0, busy}, 0);

    // R3/R11: fill to full, then drain while the card streams
    rx_load(80, 8'h33);
    go(1'b1, 16'd80);
    repeat (80) step();
    chk("R9 rx_full", {30'h0, rx_full, rx_half_full}, 2'b11);
    chk("R3 stalled at full", {16'h0, bytes_left}, 16);
    #1 chk("R3 not ready at full", {31'h0, card_rx_ready}, 0);
    drain("R11 concurrent pop word");
    wait_left0(); step(); step();
    chk("R11 idle after stream", {31'h0, busy}, 0);
    chk("R11 source consumed", rx_src.size(), 0);

    // R6: write 6 bytes of 2 words
    push_w(32'h44332211); push_w(32'h88776655);
    exp_bytes(32'h44332211); exp_tx.pop_back(); exp_tx.pop_back();
    exp_tx.push_back(8'h33); exp_tx.push_back(8'h44);
    exp_tx.push_back(8'h55); exp_tx.push_back(8'h66);
    go(1'b0, 16'd6);
    chk("R9 tx flags at 2", {27'h0, tx_active, tx_half_empty, tx_full, tx_empty, tx_avail}, 5'b11001);
    wait_left0(); step();
    chk("R6 leftover bytes dropped", {31'h0, busy}, 0);
    chk("R6 six bytes sent", exp_tx.size(), 0);
    #1 chk("R6 no byte offered", {31'h0, card_tx_valid}, 0);
    step();

    // R11: host push in same cycle as engine pop, with card stalls
    push_w(32'h03020100);
    exp_bytes(32'h03020100); exp_bytes(32'h07060504); exp_bytes(32'h0B0A0908);
    go(1'b0, 16'd12);
    push_w(32'h07060504);
    tx_mode = 1;
    step();
    push_w(32'h0B0A0908);
    wait_left0(); step();
    chk("R11 write idle", {31'h0, busy}, 0);
    chk("R11 twelve bytes sent", exp_tx.size(), 0);
    tx_mode = 0;

    // R2/R7: zero length
    go(1'b0, 16'd0);
    chk("R2 start clears end", {30'h0, data_end, block_end}, 0);
    chk("R2 start sets busy", {31'h0, busy}, 1);
    step();
    chk("R7 zero length end", {30'h0, data_end, block_end}, 2'b11);
    chk("R8 zero length idle", {31'h0, busy}, 0);

    // R9: tx half-empty boundary at 9 words
    tx_mode = 2;
    for (int k = 0; k < 9; k++) begin push_w(32'hA0000000 + k); exp_bytes(32'hA0000000 + k); end
    go(1'b0, 16'd36);
    chk("R9 half_empty off at 9", {31'h0, tx_half_empty}, 0);
    tx_mode = 0;
    step(); step();
    chk("R9 half_empty on at 8", {31'h0, tx_half_empty}, 1);
    wait_left0(); step();
    chk("R9 tx drained", exp_tx.size(), 0);

    // R9: rx half-full at exactly 8
    rx_load(32, 8'h55);
    go(1'b1, 16'd32);
    wait_left0(); step();
    chk("R9 rx half_full at 8", {29'h0, rx_half_full, rx_full, rx_avail}, 3'b101);
    drain("R4 word at half");
    step();
    chk("R8 final idle", {31'h0, busy}, 0);

    finish_run();
  end
endmodule